// File: doc/BRIEF.md
# Serial Quad Trim DAC Register Interface

This block is the digital side of a four-channel trimming DAC. A host talks to it over a three-wire serial port made of a serial clock, an active-high select and a data input, plus a program-enable line. Every access follows the same order: a start bit, then a 2-bit channel address, then an 8-bit code. The value already held for the addressed channel streams back on a data output while the new code is shifted in. Each channel has two registers. The working register drives the DAC code pins. The stored register stands in for non-volatile memory. Lowering select acts like a reset: all four working registers fall back to their stored values. So a code written without programming is only a trial setting.

All serial inputs are brought into the system clock domain through synchronizer flops. The select line is filtered, so a short low glitch does not cause a revert. A commit to the stored register starts a busy interval that stands for the slow memory write.

Top module: `quad_trim_dac`

## Requirements
- R1: After reset, each channel's working code equals its entry in INIT_VEC (channel k at bits k*CODE_W upward), the data output enable is low and busy is low.
- R2: A frame starts when a 1 is sampled on a serial clock rise while selected. The next two rises carry the address, A0 first; the channel index is A1*2+A0 (A0=1,A1=0 selects channel 1). Eight data bits follow, least significant first.
- R3: While selected, the output enable is high. After the rise that samples A1, the output carries the addressed channel's previous code, least significant bit first, and advances one bit per rise.
- R4: The addressed working code stays unchanged through D7. It takes the received code on the first serial rise after D7.
- R5: Once select has been low for SEL_FILT consecutive system clocks, the output enable drops, any partial frame is abandoned, and all four working codes equal the stored values.
- R6: A select low pulse shorter than SEL_FILT system clocks leaves every working code and the frame state unchanged.
- R7: If program-enable is high at the first serial rise after D7, the received code is copied into that channel's stored register. Busy is then high for exactly WRITE_CLKS system clocks.
- R8: A frame completed with program-enable low leaves the stored registers unchanged.
- R9: A program request that arrives while busy is high leaves the stored registers unchanged.
- R10: The two serial rises after D7 are never taken as a start bit, whatever the data input carries.
- R11: Serial clock rises while deselected change no register: no working code, no stored code, no busy, no frame progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| ser_clk | input | 1 | Serial clock, sampled by clk |
| ser_sel | input | 1 | Active-high select |
| ser_din | input | 1 | Serial data in |
| prog_en | input | 1 | Request to store the received code |
| ser_dout | output | 1 | Serial data out (old code) |
| ser_dout_oe | output | 1 | Enable for an external tri-state driver on ser_dout |
| dac_code | output | CH_NUM*CODE_W | Working codes, channel k at bits k*CODE_W upward |
| wr_busy | output | 1 | Stored-register write in progress |

## Verification
The bench goes after the points where timing around D7 decides the outcome. One test drops select right after D7. A design that applied the code one rise early would show the trial value before the revert. Another test drives ones through the two guard rises and then reads the channel back. A design that took a guard rise as a start bit would return a bit-shifted value. A further test sends a short select glitch, which a missing filter would turn into a revert of every channel. A second program request is sent while busy is still high; a design without the busy lockout would store the wrong code. Serial clocking while deselected is followed by a readback frame, so stray frame progress would show as a misread value.

// File: rtl/qtd_pkg.sv
package qtd_pkg;
   typedef enum logic [2:0] {
      FR_IDLE,
      FR_ADDR,
      FR_DATA,
      FR_APPLY,
      FR_GUARD
   } fr_state_t;
endpackage

// File: rtl/qtd_front.sv
// Input conditioning: synchronizers, serial clock rise detect, select glitch filter.
module qtd_front #(
   parameter int SYNC_STAGES = 2,
   parameter int SEL_FILT    = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic sel,
   input  logic din,
   input  logic prog,
   output logic sck_rise,
   output logic sel_f,
   output logic din_s,
   output logic prog_s
);
   localparam int FW = $clog2(SEL_FILT + 1);

   logic [SYNC_STAGES-1:0] sk_q, se_q, di_q, pg_q;
   logic                   sck_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sk_q  <= '0;
         se_q  <= '0;
         di_q  <= '0;
         pg_q  <= '0;
         sck_d <= 1'b0;
      end else begin
         sk_q  <= {sk_q[SYNC_STAGES-2:0], sck};
         se_q  <= {se_q[SYNC_STAGES-2:0], sel};
         di_q  <= {di_q[SYNC_STAGES-2:0], din};
         pg_q  <= {pg_q[SYNC_STAGES-2:0], prog};
         sck_d <= sk_q[SYNC_STAGES-1];
      end
   end

   assign sck_rise = sk_q[SYNC_STAGES-1] & ~sck_d;
   assign din_s    = di_q[SYNC_STAGES-1];
   assign prog_s   = pg_q[SYNC_STAGES-1];

   generate
      if (SEL_FILT <= 1) begin : g_nofilt
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sel_f <= 1'b0;
            else        sel_f <= se_q[SYNC_STAGES-1];
         end
      end else begin : g_filt
         logic [FW-1:0] low_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sel_f   <= 1'b0;
               low_cnt <= '0;
            end else if (se_q[SYNC_STAGES-1]) begin
               sel_f   <= 1'b1;
               low_cnt <= '0;
            end else if (sel_f) begin
               if (low_cnt == FW'(SEL_FILT - 1)) begin
                  sel_f   <= 1'b0;
                  low_cnt <= '0;
               end else begin
                  low_cnt <= low_cnt + 1'b1;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/qtd_frame.sv
// Serial frame decoder: start bit, address, data shift with old-value readback.
module qtd_frame
   import qtd_pkg::*;
#(
   parameter int CH_NUM = 4,
   parameter int CODE_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     rise,
   input  logic                     sel_f,
   input  logic                     din_s,
   input  logic                     prog_s,
   input  logic [CH_NUM*CODE_W-1:0] work_flat,
   output logic                     apply,
   output logic [$clog2(CH_NUM)-1:0] apply_addr,
   output logic [CODE_W-1:0]        apply_data,
   output logic                     apply_prog,
   output logic                     sdo
);
   localparam int AW    = $clog2(CH_NUM);
   localparam int CNT_W = $clog2(CODE_W);

   fr_state_t         st;
   logic [CNT_W-1:0]  cnt;
   logic [AW-1:0]     addr_q, nxt_addr;
   logic [CODE_W-1:0] sh_q, rd_word;
   logic              apply_q, prog_q;

   generate
      if (AW == 1) begin : g_a1
         assign nxt_addr = din_s;
      end else begin : g_an
         assign nxt_addr = {din_s, addr_q[AW-1:1]};
      end
   endgenerate

   assign rd_word = work_flat[int'(nxt_addr)*CODE_W +: CODE_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= FR_IDLE;
         cnt     <= '0;
         addr_q  <= '0;
         sh_q    <= '0;
         apply_q <= 1'b0;
         prog_q  <= 1'b0;
      end else begin
         apply_q <= 1'b0;
         if (!sel_f) begin
            st <= FR_IDLE;
         end else if (rise) begin
            unique case (st)
               FR_IDLE: if (din_s) begin
                  st  <= FR_ADDR;
                  cnt <= '0;
               end
               FR_ADDR: begin
                  addr_q <= nxt_addr;
                  if (cnt == CNT_W'(AW - 1)) begin
                     st   <= FR_DATA;
                     cnt  <= '0;
                     sh_q <= rd_word;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               FR_DATA: begin
                  sh_q <= {din_s, sh_q[CODE_W-1:1]};
                  if (cnt == CNT_W'(CODE_W - 1)) st <= FR_APPLY;
                  else                           cnt <= cnt + 1'b1;
               end
               FR_APPLY: begin
                  apply_q <= 1'b1;
                  prog_q  <= prog_s;
                  st      <= FR_GUARD;
               end
               FR_GUARD: st <= FR_IDLE;
               default:  st <= FR_IDLE;
            endcase
         end
      end
   end

   assign apply      = apply_q;
   assign apply_prog = prog_q;
   assign apply_addr = addr_q;
   assign apply_data = sh_q;
   assign sdo        = (st == FR_DATA || st == FR_APPLY || st == FR_GUARD) ? sh_q[0] : 1'b0;
endmodule

// File: rtl/qtd_bank.sv
// Working and stored code registers per channel, with the write-busy timer.
module qtd_bank #(
   parameter int                           CH_NUM     = 4,
   parameter int                           CODE_W     = 8,
   parameter int                           WRITE_CLKS = 64,
   parameter logic [CH_NUM*CODE_W-1:0]     INIT_VEC   = '0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      sel_f,
   input  logic                      apply,
   input  logic [$clog2(CH_NUM)-1:0] apply_addr,
   input  logic [CODE_W-1:0]         apply_data,
   input  logic                      apply_prog,
   output logic [CH_NUM*CODE_W-1:0]  work_flat,
   output logic [CH_NUM*CODE_W-1:0]  store_flat,
   output logic                      busy
);
   localparam int AW = $clog2(CH_NUM);
   localparam int BW = $clog2(WRITE_CLKS + 1);

   logic [BW-1:0] busy_cnt;
   logic          commit;

   assign commit = apply & apply_prog & ~busy & sel_f;
   assign busy   = (busy_cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          busy_cnt <= '0;
      else if (commit)     busy_cnt <= BW'(WRITE_CLKS);
      else if (busy)       busy_cnt <= busy_cnt - 1'b1;
   end

   generate
      for (genvar g = 0; g < CH_NUM; g++) begin : g_ch
         logic [CODE_W-1:0] w_r, s_r;
         logic              hit;
         assign hit = (apply_addr == AW'(g));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               w_r <= INIT_VEC[g*CODE_W +: CODE_W];
               s_r <= INIT_VEC[g*CODE_W +: CODE_W];
            end else begin
               if (!sel_f)           w_r <= s_r;
               else if (apply && hit) w_r <= apply_data;
               if (commit && hit)    s_r <= apply_data;
            end
         end
         assign work_flat[g*CODE_W +: CODE_W]  = w_r;
         assign store_flat[g*CODE_W +: CODE_W] = s_r;
      end
   endgenerate
endmodule

// File: rtl/quad_trim_dac.sv
module quad_trim_dac #(
   parameter int                       CH_NUM      = 4,
   parameter int                       CODE_W      = 8,
   parameter int                       SYNC_STAGES = 2,
   parameter int                       SEL_FILT    = 4,
   parameter int                       WRITE_CLKS  = 64,
   parameter logic [CH_NUM*CODE_W-1:0] INIT_VEC    = {CH_NUM{1'b1, {(CODE_W-1){1'b0}}}}
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ser_clk,
   input  logic                     ser_sel,
   input  logic                     ser_din,
   input  logic                     prog_en,
   output logic                     ser_dout,
   output logic                     ser_dout_oe,
   output logic [CH_NUM*CODE_W-1:0] dac_code,
   output logic                     wr_busy
);
   localparam int AW = $clog2(CH_NUM);

   generate
      if (CH_NUM < 2 || (CH_NUM & (CH_NUM - 1)) != 0) begin : g_bad_ch
         $error("CH_NUM must be a power of two, at least 2");
      end
      if (AW > CODE_W) begin : g_bad_w
         $error("address wider than code");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (WRITE_CLKS < 1 || SEL_FILT < 1) begin : g_bad_cnt
         $error("WRITE_CLKS and SEL_FILT must be positive");
      end
   endgenerate

   logic              sck_rise, sel_f, din_s, prog_s;
   logic              apply_p, apply_prog, sdo;
   logic [AW-1:0]     apply_addr;
   logic [CODE_W-1:0] apply_data;
   logic [CH_NUM*CODE_W-1:0] work_flat, store_flat;

   qtd_front #(.SYNC_STAGES(SYNC_STAGES), .SEL_FILT(SEL_FILT)) u_front (
      .clk(clk), .rst_n(rst_n), .sck(ser_clk), .sel(ser_sel), .din(ser_din),
      .prog(prog_en), .sck_rise(sck_rise), .sel_f(sel_f), .din_s(din_s), .prog_s(prog_s)
   );

   qtd_frame #(.CH_NUM(CH_NUM), .CODE_W(CODE_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .rise(sck_rise), .sel_f(sel_f), .din_s(din_s),
      .prog_s(prog_s), .work_flat(work_flat), .apply(apply_p), .apply_addr(apply_addr),
      .apply_data(apply_data), .apply_prog(apply_prog), .sdo(sdo)
   );

   qtd_bank #(.CH_NUM(CH_NUM), .CODE_W(CODE_W), .WRITE_CLKS(WRITE_CLKS), .INIT_VEC(INIT_VEC)) u_bank (
      .clk(clk), .rst_n(rst_n), .sel_f(sel_f), .apply(apply_p), .apply_addr(apply_addr),
      .apply_data(apply_data), .apply_prog(apply_prog), .work_flat(work_flat),
      .store_flat(store_flat), .busy(wr_busy)
   );

   assign dac_code    = work_flat;
   assign ser_dout_oe = sel_f;
   assign ser_dout    = sdo & sel_f;
endmodule

// File: rtl/qtd_checker.sv
module qtd_checker #(
   parameter int CH_NUM     = 4,
   parameter int CODE_W     = 8,
   parameter int WRITE_CLKS = 64
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     sel_f,
   input logic                     apply,
   input logic                     busy,
   input logic [CH_NUM*CODE_W-1:0] code,
   input logic [CH_NUM*CODE_W-1:0] store
);
   int unsigned run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_q <= 0;
      else if (busy) run_q <= run_q + 1;
      else           run_q <= 0;
   end

   AST_RELOAD_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_f |=> code == $past(store)); // R5

   AST_STORE_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(store)); // R9

   AST_STORE_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(store) |-> $past(apply)); // R7

   AST_CODE_MOVES_ON_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(code) |-> ($past(apply) || !$past(sel_f))); // R4

   AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> run_q == WRITE_CLKS); // R7
endmodule

bind quad_trim_dac qtd_checker #(.CH_NUM(CH_NUM), .CODE_W(CODE_W), .WRITE_CLKS(WRITE_CLKS)) u_chk (
   .clk(clk), .rst_n(rst_n), .sel_f(sel_f), .apply(apply_p), .busy(wr_busy),
   .code(dac_code), .store(store_flat)
);

// File: tb/quad_trim_dac_test.sv
`timescale 1ns/1ps
module quad_trim_dac_test;
   localparam int WCLK = 200;
   localparam logic [31:0] INIT = {8'hA4, 8'h5B, 8'h3C, 8'h10};
   // vector: {prog, ch[1:0], data[7:0]}
   localparam int NV = 6;
   localparam logic [10:0] VEC [NV] = '{
      {1'b0, 2'd0, 8'hC3}, {1'b1, 2'd3, 8'h01}, {1'b0, 2'd1, 8'hFF},
      {1'b1, 2'd2, 8'h00}, {1'b1, 2'd0, 8'h5A}, {1'b0, 2'd3, 8'h80}};

   logic clk = 1'b0, rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_sel = 1'b0, ser_din = 1'b0, prog_en = 1'b0;
   logic ser_dout, ser_dout_oe, wr_busy;
   logic [31:0] code;

   int total = 0, bad = 0;
   int run = 0, last_run = 0;
   logic [7:0] work [4];
   logic [7:0] shad [4];

   always #2.5 clk = ~clk;

   quad_trim_dac #(.SEL_FILT(4), .WRITE_CLKS(WCLK), .INIT_VEC(INIT)) uut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_sel(ser_sel), .ser_din(ser_din),
      .prog_en(prog_en), .ser_dout(ser_dout), .ser_dout_oe(ser_dout_oe),
      .dac_code(code), .wr_busy(wr_busy));

   always @(negedge clk) begin
      if (wr_busy) run <= run + 1;
      else if (run != 0) begin last_run <= run; run <= 0; end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic pulse(input logic b, output logic q);
      ser_din = b;
      repeat (4) @(posedge clk);
      @(negedge clk) q = ser_dout;
      ser_clk = 1'b1;
      repeat (4) @(posedge clk);
      ser_clk = 1'b0;
   endtask

   task automatic frame(input int ch, input logic [7:0] d, input logic pg,
                        input bit tail, input logic tail_din, output logic [7:0] rd);
      logic q;
      pulse(1'b1, q);
      pulse(ch[0], q);
      pulse(ch[1], q);
      for (int i = 0; i < 8; i++) begin
         pulse(d[i], q);
         rd[i] = q;
      end
      if (tail) begin
         prog_en = pg;
         pulse(tail_din, q);
         pulse(tail_din, q);
         prog_en = 1'b0;
      end
      repeat (8) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic deselect(input int n);
      ser_sel = 1'b0;
      repeat (n) @(posedge clk);
      ser_sel = 1'b1;
      repeat (8) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 1000 && wr_busy; i++) @(negedge clk);
   endtask

   function automatic logic [31:0] pack(input logic [7:0] a [4]);
      return {a[3], a[2], a[1], a[0]};
   endfunction

   initial begin
      #(200000 * 5);
      total++; bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] rd;
      for (int i = 0; i < 4; i++) begin
         work[i] = INIT[i*8 +: 8];
         shad[i] = INIT[i*8 +: 8];
      end
      repeat (5) @(posedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 codes", code, INIT);
      chk("R1 oe", {31'd0, ser_dout_oe}, 32'd0);
      chk("R1 busy", {31'd0, wr_busy}, 32'd0);

      ser_sel = 1'b1;
      repeat (8) @(negedge clk);
      chk("R3 oe high", {31'd0, ser_dout_oe}, 32'd1);

      // table walk: R2 R3 R4 R7 R8
      for (int v = 0; v < NV; v++) begin
         int ch;
         ch = int'(VEC[v][9:8]);
         frame(ch, VEC[v][7:0], VEC[v][10], 1'b1, 1'b0, rd);
         chk("R3 readback", {24'd0, rd}, {24'd0, work[ch]});
         work[ch] = VEC[v][7:0];
         if (VEC[v][10]) shad[ch] = VEC[v][7:0];
         chk("R2 R4 codes", code, pack(work));
         wait_idle();
      end
      deselect(10);
      chk("R5 R8 revert", code, pack(shad));
      for (int i = 0; i < 4; i++) work[i] = shad[i];

      // R6 glitch
      frame(1, 8'h77, 1'b0, 1'b1, 1'b0, rd);
      work[1] = 8'h77;
      deselect(2);
      chk("R6 glitch ignored", code, pack(work));
      deselect(10);
      for (int i = 0; i < 4; i++) work[i] = shad[i];
      chk("R5 revert", code, pack(shad));

      // R11 clocks while deselected
      ser_sel = 1'b0;
      repeat (10) @(posedge clk);
      frame(2, 8'hEE, 1'b1, 1'b1, 1'b0, rd);
      chk("R11 codes", code, pack(shad));
      chk("R11 busy", {31'd0, wr_busy}, 32'd0);
      ser_sel = 1'b1;
      repeat (8) @(posedge clk);
      frame(2, 8'h99, 1'b0, 1'b1, 1'b0, rd);
      chk("R11 frame state", {24'd0, rd}, {24'd0, shad[2]});
      work[2] = 8'h99;

      // R4 abort right after D7
      frame(0, 8'h3E, 1'b1, 1'b0, 1'b0, rd);
      chk("R4 readback", {24'd0, rd}, {24'd0, work[0]});
      chk("R4 not yet applied", code, pack(work));
      deselect(10);
      for (int i = 0; i < 4; i++) work[i] = shad[i];
      chk("R4 R8 abort revert", code, pack(shad));

      // R10 guard rises carry ones
      frame(3, 8'h66, 1'b0, 1'b1, 1'b1, rd);
      frame(3, 8'h67, 1'b0, 1'b1, 1'b0, rd);
      chk("R10 guard", {24'd0, rd}, {24'd0, 8'h66});
      work[3] = 8'h67;
      chk("R10 codes", code, pack(work));

      // R7 R9 commit and busy lockout
      frame(1, 8'hB1, 1'b1, 1'b1, 1'b0, rd);
      chk("R7 busy", {31'd0, wr_busy}, 32'd1);
      shad[1] = 8'hB1;
      frame(1, 8'hB2, 1'b1, 1'b1, 1'b0, rd);
      chk("R9 readback", {24'd0, rd}, {24'd0, 8'hB1});
      wait_idle();
      repeat (3) @(negedge clk);
      chk("R7 busy length", last_run, WCLK);
      deselect(10);
      chk("R9 R7 stored", code, pack(shad));

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule